// File: doc/BRIEF.md
# Fixed-Map Nested Interrupt Controller

A small interrupt controller for an embedded port processor. It serves exactly four sources, each tied to a fixed IRQ number: an internal periodic tick on IRQ0, serial port B on IRQ3, serial port A on IRQ4 and the network interface on IRQ5. A rising edge on a source latches a pending request. Pending requests that are not masked and that outrank everything in service raise one interrupt line to the CPU. Priority never changes and follows the IRQ number: IRQ0 > IRQ3 > IRQ4 > IRQ5.

The CPU pulses an acknowledge input. One cycle later the block returns the IRQ number of the winning request and moves that request from pending to in-service. An in-service bit is cleared only by a specific end-of-interrupt command that names the IRQ. Every other command form is ignored.

A small register bus gives access to the mask. It also takes the end-of-interrupt command and lets software read the pending and in-service state. The tick source is generated inside the block. At the default parameter and a 125 MHz clock it fires every 10 ms.

Top module: `fixed_nest_pic`

## Requirements
- R1: After reset the mask, pending and in-service registers all read zero, and both `intr` and `ack_valid` are low.
- R2: A rising edge on `ext_req[k]` sets the pending bit of its IRQ. The mapping is k=0 to IRQ3, k=1 to IRQ4 and k=2 to IRQ5. Holding the input high raises no further request. Pending bits read at bus address 1, with each IRQ shown at the bit position equal to its number.
- R3: The internal tick sets pending bit 0 once every TICK_CYCLES clock edges. The first one comes on the TICK_CYCLES-th edge after reset is released.
- R4: Bus address 0 holds the mask. Write bits 0, 3, 4 and 5 mask the IRQ of the same number, and all other bits read zero. A masked source still latches its pending bit but never raises `intr`.
- R5: `intr` is high exactly when some unmasked pending IRQ has higher priority than every in-service IRQ. The priority order is IRQ0 > IRQ3 > IRQ4 > IRQ5.
- R6: When `inta` is high at a clock edge and `intr` is high, `ack_valid` is high for the next cycle and `ack_vec` carries the winning IRQ number. At that same edge the winner's pending bit clears and its in-service bit sets.
- R7: An `inta` with no eligible request returns `ack_vec` = 7 with `ack_valid` high, and changes no state.
- R8: A write to bus address 1 of value 0x60 plus an IRQ number clears that IRQ's in-service bit. If the named IRQ is not in service or not supported, the write has no effect. In-service bits read at bus address 2, in the same bit layout as the pending bits.
- R9: A write to address 1 whose upper five bits are not 01100 is ignored. This covers the non-specific (0x20) and rotating (0xA0) forms.
- R10: While an IRQ is in service, requests of equal or lower priority do not raise `intr`, but higher ones still do.
- R11: Bus reads are combinational, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 3 | External sources: bit0 IRQ3, bit1 IRQ4, bit2 IRQ5 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| inta | input | 1 | Interrupt acknowledge |
| intr | output | 1 | Interrupt request to the CPU |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | 3 | Granted IRQ number, 7 if spurious |

## Verification
Directed sequences run first. The first waits out the tick to pin down the exact cycle it arrives. Next, all sources are raised while masked, which separates latching a request from signalling it. A nested acknowledge then shows that a lower IRQ is blocked while a higher one still breaks through. The EOI stage tries a non-specific command, a specific command naming an idle IRQ and a correct specific command; these tell rejection, no-op and retirement apart. Constrained random traffic then mixes source edges, acknowledges, mask writes and EOI values, both valid and invalid. Every cycle is compared against a requirement-level model, which catches priority and simultaneous set/clear interactions.

// File: rtl/fixed_nest_pic.sv
module fixed_nest_pic #(
  parameter int TICK_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ext_req,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       inta,
  output logic       intr,
  output logic       ack_valid,
  output logic [2:0] ack_vec
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] TICK_LAST = CW'(TICK_CYCLES - 1);
  localparam logic [2:0] SPURIOUS = 3'd7;
  localparam logic [4:0] SEOI_TAG = 5'b01100;

  // slot order is priority order: slot0 = IRQ0 (tick), 1 = IRQ3, 2 = IRQ4, 3 = IRQ5
  function automatic logic [2:0] irq_of(input int s);
    case (s)
      0: irq_of = 3'd0;
      1: irq_of = 3'd3;
      2: irq_of = 3'd4;
      default: irq_of = 3'd5;
    endcase
  endfunction

  function automatic logic [7:0] spread(input logic [3:0] v);
    spread = {2'b00, v[3], v[2], v[1], 2'b00, v[0]};
  endfunction

  logic [CW-1:0] tick_cnt;
  logic          tick;
  logic [2:0]    ext_q;
  logic [3:0]    irr, isr, mask;
  logic [3:0]    elig, grant, take, eoi_clr, req_set;
  logic [2:0]    win_irq;
  logic          eoi_hit;

  assign tick    = (tick_cnt == TICK_LAST);
  assign req_set = {ext_req & ~ext_q, tick};
  assign eoi_hit = bus_wr && (bus_addr == 2'd1) && (bus_wdata[7:3] == SEOI_TAG);
  assign take    = inta ? grant : 4'b0000;
  assign intr    = |elig;

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < 4; i++) begin
      blocked = blocked | isr[i];
      elig[i] = irr[i] & ~mask[i] & ~blocked;
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    grant   = '0;
    win_irq = SPURIOUS;
    for (int i = 0; i < 4; i++) begin
      if (elig[i] && !found) begin
        grant[i] = 1'b1;
        win_irq  = irq_of(i);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++)
      eoi_clr[i] = eoi_hit && (bus_wdata[2:0] == irq_of(i));
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = spread(mask);
      2'd1:    bus_rdata = spread(irr);
      2'd2:    bus_rdata = spread(isr);
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      ext_q     <= '0;
      irr       <= '0;
      isr       <= '0;
      mask      <= '0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      tick_cnt  <= tick ? '0 : tick_cnt + 1'b1;
      ext_q     <= ext_req;
      irr       <= (irr & ~take) | req_set;
      isr       <= (isr & ~eoi_clr) | take;
      ack_valid <= inta;
      if (inta) ack_vec <= win_irq;
      if (bus_wr && bus_addr == 2'd0)
        mask <= {bus_wdata[5], bus_wdata[4], bus_wdata[3], bus_wdata[0]};
    end
  end
endmodule

module fixed_nest_pic_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inta,
  input logic       intr,
  input logic       ack_valid,
  input logic [2:0] ack_vec,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [3:0] mask,
  input logic [3:0] isr
);
  // R6
  ack_follows_inta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(inta));
  // R6
  tick_grant_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_vec == 3'd0) |-> isr[0]);
  // R4
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !intr);
  // R9
  bad_eoi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && bus_wdata[7:3] != 5'b01100 && !inta) |=> $stable(isr));
  // R10
  top_in_service_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr[0] |-> !intr);
  // R6
  isr_grows_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(isr) > $countones($past(isr))) |-> $past(inta));
endmodule

bind fixed_nest_pic fixed_nest_pic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .intr(intr), .ack_valid(ack_valid),
  .ack_vec(ack_vec), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mask(mask), .isr(isr)
);

// File: tb/sim_fixed_nest_pic.sv
module sim_fixed_nest_pic;
  localparam int TICK = 97;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ext_req = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       inta = 1'b0;
  logic       intr, ack_valid;
  logic [2:0] ack_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_irr, m_isr, m_mask;
  logic [2:0] m_extq;
  int         m_cnt;
  logic       m_av;
  logic [2:0] m_vec;

  fixed_nest_pic #(.TICK_CYCLES(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .inta(inta), .intr(intr), .ack_valid(ack_valid), .ack_vec(ack_vec)
  );

  always #4 clk = ~clk;

  function automatic logic [2:0] irq_n(input int s);
    case (s) 0: irq_n = 3'd0; 1: irq_n = 3'd3; 2: irq_n = 3'd4; default: irq_n = 3'd5; endcase
  endfunction

  function automatic logic [7:0] lay(input logic [3:0] v);
    lay = {2'b00, v[3], v[2], v[1], 2'b00, v[0]};
  endfunction

  function automatic logic [3:0] exp_elig();
    logic b = 1'b0;
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      b = b | m_isr[i];
      r[i] = m_irr[i] & ~m_mask[i] & ~b;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a) 2'd0: exp_rd = lay(m_mask); 2'd1: exp_rd = lay(m_irr);
             2'd2: exp_rd = lay(m_isr); default: exp_rd = 8'h00; endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_mask = '0; m_extq = '0; m_cnt = 0; m_av = 0; m_vec = '0;
  endtask

  task automatic model_step();
    logic [3:0] el, gr, clr, st;
    logic [2:0] wv;
    el = exp_elig(); gr = '0; wv = 3'd7;
    for (int i = 0; i < 4; i++)
      if (el[i] && gr == 4'b0) begin gr[i] = 1'b1; wv = irq_n(i); end
    if (!inta) gr = '0;
    clr = '0;
    if (bus_wr && bus_addr == 2'd1 && bus_wdata[7:3] == 5'b01100)
      for (int i = 0; i < 4; i++) if (bus_wdata[2:0] == irq_n(i)) clr[i] = 1'b1;
    st = {ext_req & ~m_extq, m_cnt == TICK - 1};
    m_irr = (m_irr & ~gr) | st;
    m_isr = (m_isr & ~clr) | gr;
    m_av = inta;
    if (inta) m_vec = wv;
    if (bus_wr && bus_addr == 2'd0) m_mask = {bus_wdata[5], bus_wdata[4], bus_wdata[3], bus_wdata[0]};
    m_extq = ext_req;
    m_cnt = (m_cnt == TICK - 1) ? 0 : m_cnt + 1;
  endtask

  task automatic compare();
    string rt;
    chk(intr, |exp_elig(), "R5 intr");
    chk(ack_valid, m_av, "R6 ack_valid");
    if (m_av) chk(ack_vec, m_vec, (m_vec == 3'd7) ? "R7 spurious vec" : "R6 ack_vec");
    case (bus_addr) 2'd0: rt = "R4 mask read"; 2'd1: rt = "R2 pending read";
                    2'd2: rt = "R8 in-service read"; default: rt = "R11 addr3 read"; endcase
    chk(bus_rdata, exp_rd(bus_addr), rt);
  endtask

  task automatic cyc(input logic [2:0] e, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input logic ia);
    ext_req = e; bus_wr = w; bus_addr = a; bus_wdata = d; inta = ia;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] e;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: state right after reset
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1;
      chk(bus_rdata, 8'h00, "R1 reset read");
    end
    chk(intr, 1'b0, "R1 intr"); chk(ack_valid, 1'b0, "R1 ack_valid");

    // R3: tick lands on edge TICK, not before
    repeat (TICK - 1) cyc(3'b000, 0, 2'd1, 8'h00, 0);
    chk(bus_rdata[0], 1'b0, "R3 before tick");
    cyc(3'b000, 0, 2'd1, 8'h00, 0);
    chk(bus_rdata[0], 1'b1, "R3 tick");
    cyc(3'b000, 0, 2'd2, 8'h00, 1);
    chk(ack_vec, 3'd0, "R6 tick vector");
    cyc(3'b000, 1, 2'd1, 8'h60, 0);

    // R4: masked sources latch but stay quiet
    cyc(3'b000, 1, 2'd0, 8'hFF, 0);
    cyc(3'b111, 0, 2'd1, 8'h00, 0);
    cyc(3'b111, 0, 2'd1, 8'h00, 0);
    chk(bus_rdata, 8'h38, "R4 masked latch");
    chk(intr, 1'b0, "R4 masked intr");
    cyc(3'b111, 1, 2'd0, 8'h00, 0);
    chk(intr, 1'b1, "R5 unmasked intr");
    cyc(3'b111, 0, 2'd2, 8'h00, 1);
    chk(ack_vec, 3'd3, "R5 priority IRQ3 first");
    // R10: IRQ3 in service blocks IRQ4/IRQ5
    chk(intr, 1'b0, "R10 lower blocked");
    cyc(3'b111, 1, 2'd1, 8'h20, 0);
    chk(m_isr, 4'b0010, "R9 model sanity");
    cyc(3'b111, 0, 2'd2, 8'h00, 0);
    chk(bus_rdata, 8'h08, "R9 non-specific ignored");
    cyc(3'b111, 1, 2'd1, 8'hA3, 0);
    cyc(3'b111, 1, 2'd1, 8'h64, 0);
    cyc(3'b111, 0, 2'd2, 8'h00, 0);
    chk(bus_rdata, 8'h08, "R8 idle EOI no effect");
    cyc(3'b111, 1, 2'd1, 8'h63, 0);
    cyc(3'b111, 0, 2'd2, 8'h00, 0);
    chk(bus_rdata, 8'h00, "R8 specific EOI clears");
    chk(intr, 1'b1, "R8 intr recomputed");
    cyc(3'b111, 0, 2'd2, 8'h00, 1);
    chk(ack_vec, 3'd4, "R6 next vector");
    cyc(3'b111, 0, 2'd2, 8'h00, 1);
    chk(ack_vec, 3'd7, "R7 blocked ack spurious");
    chk(bus_rdata, 8'h10, "R7 no state change");
    cyc(3'b111, 0, 2'd3, 8'h00, 0);
    chk(bus_rdata, 8'h00, "R11 addr3");

    // random traffic
    e = 3'b000;
    for (int n = 0; n < 4000; n++) begin
      logic w; logic [1:0] a; logic [7:0] d; logic ia;
      if ($urandom_range(0, 5) == 0) e = e ^ 3'($urandom_range(1, 7));
      w = ($urandom_range(0, 4) == 0);
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 2'd1) begin
        case ($urandom_range(0, 5))
          0, 1, 2: d = 8'h60 | {5'b0, irq_n($urandom_range(0, 3))};
          3: d = 8'h61;
          4: d = 8'h20;
          default: ;
        endcase
      end
      if (a == 2'd0 && $urandom_range(0, 1) == 0) d = 8'h00;
      ia = ($urandom_range(0, 5) == 0);
      cyc(e, w, a, d, ia);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule